// File: doc/BRIEF.md
# Frame-ready request pacing timer

This block sits beside a transmit FIFO and decides when a complete frame waiting in that FIFO may raise a service request. Software supplies a 16-bit period value, a timer enable and a frame-mode enable. The FIFO supplies a level that says a whole frame is present, plus one-cycle strobes for every access to its data port. The block's output is the frame-ready request that the DMA engine or host sees. The FIFO's fill-level alarm request passes through the block unchanged.

With frame mode off, no frame request is produced. With frame mode on and the timer off, or with a period of zero, the request follows the frame-present level. With frame mode and timer both on and a nonzero period, a free-running prescaler divides the clock by 64. Its ticks are counted against the period, so a single-cycle request fires every period × 64 cycles while a frame stays present. Any data-port read or write restarts the count. This is because either the consumer is already servicing the FIFO or more data is still arriving.

Top module: `frame_pace_timer`

## Requirements
- R1: While `frame_mode_en` is 0, `frame_req` is 0 in every cycle, whatever the other inputs are.
- R2: While `frame_mode_en` is 1 and `pace_en` is 0, `frame_req` equals `frame_present` in the same cycle.
- R3: While `frame_mode_en` and `pace_en` are 1 and `pace_period` is 0, `frame_req` equals `frame_present` in the same cycle.
- R4: In paced mode (both enables 1, `pace_period` = P > 0), counting the first cycle in which `frame_present` is high as cycle 0, `frame_req` is 0 in cycles 0 to 64·P−2 and 1 in cycle 64·P−1.
- R5: In paced mode, while `frame_present` stays high with no data-port access, `frame_req` is a one-cycle pulse that repeats every 64·P cycles.
- R6: In paced mode, a cycle with `data_wr` or `data_rd` high never shows `frame_req`, and it restarts the count: the next pulse comes 64·P cycles after that strobe cycle.
- R7: In paced mode, `frame_req` is 0 while `frame_present` is low. After `frame_present` rises again, the count starts over from cycle 0 as in R4.
- R8: `alarm_req` equals `alarm_in` in every cycle and every mode.
- R9: While `rst_n` is low, `frame_req` is 0 even in paced mode with a frame present. After release, the first pulse comes in the 64·P-th cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pace_period | input | 16 | Request period in units of 64 cycles; 0 means no pacing |
| pace_en | input | 1 | Enables paced requests |
| frame_mode_en | input | 1 | Enables frame requests at all |
| frame_present | input | 1 | A complete frame is held in the FIFO |
| data_wr | input | 1 | Write strobe on the FIFO data port |
| data_rd | input | 1 | Read strobe on the FIFO data port |
| alarm_in | input | 1 | Fill-level alarm from the FIFO |
| alarm_req | output | 1 | Alarm request, passed through |
| frame_req | output | 1 | Paced frame-ready request |

## Verification
The hardest case to reach from the ports is a data-port strobe that lands in the exact cycle the count expires. The strobe has to both suppress that pulse and push the next one out by a full period. The stimulus raises `frame_present` right after a clock edge so that the cycle index is known. It then places a read strobe in cycle 63 with a one-tick period, and a write strobe in mid-count with a two-tick period, and checks `frame_req` in every cycle of each window. A third window drops `frame_present` in mid-count to show that the count starts over.

// File: rtl/frame_pace_pkg.sv
package frame_pace_pkg;

   typedef enum logic [1:0] {
      PACE_OFF   = 2'd0,
      PACE_PASS  = 2'd1,
      PACE_TIMED = 2'd2
   } pace_mode_e;

   localparam int unsigned DEF_PERIOD_W   = 16;
   localparam int unsigned DEF_PRESCALE_W = 6;

endpackage

// File: rtl/fpt_mode_decode.sv
module fpt_mode_decode
   import frame_pace_pkg::*;
#(
   parameter int unsigned PERIOD_W = DEF_PERIOD_W
) (
   input  logic                frame_mode_en,
   input  logic                pace_en,
   input  logic [PERIOD_W-1:0] pace_period,
   output pace_mode_e          mode
);

   logic period_zero;

   assign period_zero = (pace_period == '0);

   always_comb begin
      if (!frame_mode_en) begin
         mode = PACE_OFF;
      end else if (!pace_en || period_zero) begin
         mode = PACE_PASS;
      end else begin
         mode = PACE_TIMED;
      end
   end

endmodule

// File: rtl/fpt_prescaler.sv
module fpt_prescaler #(
   parameter int unsigned PRESCALE_W = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic tick
);

   generate
      if (PRESCALE_W == 0) begin : g_no_div
         assign tick = run && !clear;
      end else begin : g_div
         localparam logic [PRESCALE_W-1:0] LAST = {PRESCALE_W{1'b1}};
         logic [PRESCALE_W-1:0] phase_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (clear) begin
               phase_q <= '0;
            end else if (run) begin
               phase_q <= phase_q + 1'b1;
            end
         end

         assign tick = run && !clear && (phase_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/fpt_period_counter.sv
module fpt_period_counter #(
   parameter int unsigned PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                tick,
   input  logic [PERIOD_W-1:0] pace_period,
   output logic                expire
);

   localparam int unsigned EXT_W = PERIOD_W + 1;

   logic [PERIOD_W-1:0] ticks_q;
   logic [EXT_W-1:0]    ticks_next;

   assign ticks_next = {1'b0, ticks_q} + 1'b1;
   assign expire     = tick && (ticks_next >= {1'b0, pace_period});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ticks_q <= '0;
      end else if (clear) begin
         ticks_q <= '0;
      end else if (tick) begin
         if (expire) begin
            ticks_q <= '0;
         end else begin
            ticks_q <= ticks_next[PERIOD_W-1:0];
         end
      end
   end

endmodule

// File: rtl/fpt_req_gate.sv
module fpt_req_gate
   import frame_pace_pkg::*;
(
   input  pace_mode_e mode,
   input  logic       frame_present,
   input  logic       expire,
   input  logic       restart,
   output logic       frame_req
);

   always_comb begin
      unique case (mode)
         PACE_PASS:  frame_req = frame_present;
         PACE_TIMED: frame_req = frame_present && expire && !restart;
         default:    frame_req = 1'b0;
      endcase
   end

endmodule

// File: rtl/frame_pace_timer.sv
module frame_pace_timer
   import frame_pace_pkg::*;
#(
   parameter int unsigned PERIOD_W   = DEF_PERIOD_W,
   parameter int unsigned PRESCALE_W = DEF_PRESCALE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PERIOD_W-1:0] pace_period,
   input  logic                pace_en,
   input  logic                frame_mode_en,
   input  logic                frame_present,
   input  logic                data_wr,
   input  logic                data_rd,
   input  logic                alarm_in,
   output logic                alarm_req,
   output logic                frame_req
);

   generate
      if (PERIOD_W < 1 || PERIOD_W > 32) begin : g_bad_period_w
         $error("frame_pace_timer: PERIOD_W must be 1..32");
      end
      if (PRESCALE_W > 16) begin : g_bad_prescale_w
         $error("frame_pace_timer: PRESCALE_W must be 0..16");
      end
   endgenerate

   pace_mode_e mode;
   logic       restart;
   logic       run;
   logic       clear;
   logic       tick;
   logic       expire;

   assign restart = data_wr || data_rd;
   assign run     = (mode == PACE_TIMED) && frame_present;
   assign clear   = restart || !run;

   fpt_mode_decode #(.PERIOD_W(PERIOD_W)) u_mode (
      .frame_mode_en (frame_mode_en),
      .pace_en       (pace_en),
      .pace_period   (pace_period),
      .mode          (mode)
   );

   fpt_prescaler #(.PRESCALE_W(PRESCALE_W)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .run   (run),
      .tick  (tick)
   );

   fpt_period_counter #(.PERIOD_W(PERIOD_W)) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (clear),
      .tick        (tick),
      .pace_period (pace_period),
      .expire      (expire)
   );

   fpt_req_gate u_gate (
      .mode          (mode),
      .frame_present (frame_present),
      .expire        (expire && rst_n),
      .restart       (restart),
      .frame_req     (frame_req)
   );

   assign alarm_req = alarm_in;

endmodule

// File: rtl/frame_pace_timer_chk.sv
module frame_pace_timer_chk #(
   parameter int unsigned PERIOD_W   = 16,
   parameter int unsigned PRESCALE_W = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic [PERIOD_W-1:0] pace_period,
   input logic                pace_en,
   input logic                frame_mode_en,
   input logic                frame_present,
   input logic                data_wr,
   input logic                data_rd,
   input logic                alarm_in,
   input logic                alarm_req,
   input logic                frame_req
);

   logic        timed;
   logic        strobe;
   logic [47:0] run_len;
   logic [47:0] span;

   assign timed  = frame_mode_en && pace_en && (pace_period != '0);
   assign strobe = data_wr || data_rd;
   assign span   = 48'(pace_period) << PRESCALE_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len <= '0;
      end else if (timed && frame_present && !strobe) begin
         run_len <= run_len + 1'b1;
      end else begin
         run_len <= '0;
      end
   end

   assert_off_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_mode_en |-> !frame_req);

   assert_pass_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_mode_en && !pace_en) |-> (frame_req == frame_present));

   assert_zero_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_mode_en && pace_en && pace_period == '0) |-> (frame_req == frame_present));

   assert_pulse_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (timed && frame_req) |-> (((run_len + 1'b1) % span) == '0));

   assert_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (timed && frame_req) |=> !(timed && frame_req));

   assert_strobe_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (timed && strobe) |-> !frame_req);

   assert_needs_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (timed && !frame_present) |-> !frame_req);

   assert_alarm_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_req == alarm_in);

endmodule

bind frame_pace_timer frame_pace_timer_chk #(
   .PERIOD_W   (PERIOD_W),
   .PRESCALE_W (PRESCALE_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pace_period   (pace_period),
   .pace_en       (pace_en),
   .frame_mode_en (frame_mode_en),
   .frame_present (frame_present),
   .data_wr       (data_wr),
   .data_rd       (data_rd),
   .alarm_in      (alarm_in),
   .alarm_req     (alarm_req),
   .frame_req     (frame_req)
);

// File: tb/frame_pace_timer_tb.sv
`timescale 1ns/1ps
module frame_pace_timer_tb;

   localparam int unsigned PW = 16;
   localparam int          NVEC = 10;
   localparam time         HALF = 2.5ns;
   localparam time         WATCHDOG = 200000 * 5ns;

   // fields: [10:7] req tag, [6] frame_mode_en, [5] pace_en, [4] period zero,
   // [3] frame_present, [2] alarm_in, [1] expected frame_req, [0] expected alarm_req
   localparam logic [10:0] VEC [NVEC] = '{
      {4'd1, 7'b0_1_0_1_1_0_1},
      {4'd1, 7'b0_0_0_1_0_0_0},
      {4'd2, 7'b1_0_0_1_0_1_0},
      {4'd2, 7'b1_0_1_0_1_0_1},
      {4'd3, 7'b1_1_1_1_0_1_0},
      {4'd3, 7'b1_1_1_0_1_0_1},
      {4'd4, 7'b1_1_0_1_1_0_1},
      {4'd8, 7'b0_0_0_0_1_0_1},
      {4'd8, 7'b1_0_0_1_1_1_1},
      {4'd8, 7'b1_1_0_0_0_0_0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] pace_period = '0;
   logic          pace_en = 1'b0;
   logic          frame_mode_en = 1'b0;
   logic          frame_present = 1'b0;
   logic          data_wr = 1'b0;
   logic          data_rd = 1'b0;
   logic          alarm_in = 1'b0;
   logic          alarm_req;
   logic          frame_req;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  finished = 1'b0;

   always #HALF clk = ~clk;

   frame_pace_timer #(.PERIOD_W(PW)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .pace_period   (pace_period),
      .pace_en       (pace_en),
      .frame_mode_en (frame_mode_en),
      .frame_present (frame_present),
      .data_wr       (data_wr),
      .data_rd       (data_rd),
      .alarm_in      (alarm_in),
      .alarm_req     (alarm_req),
      .frame_req     (frame_req)
   );

   function automatic string tag_name(input logic [3:0] t);
      case (t)
         4'd1: return "R1";
         4'd2: return "R2";
         4'd3: return "R3";
         4'd4: return "R4";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(input logic act, input logic exp, input string what);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %0b expected %0b", what, act, exp);
      end
   endtask

   task automatic next_cycle();
      @(posedge clk);
      #1;
   endtask

   // Caller is just past an edge; the current cycle is index 0.
   task automatic run_window(input int ncyc, input int pa, input int pb,
                             input int strobe_at, input bit use_rd, input string what);
      for (int c = 0; c < ncyc; c++) begin
         data_wr = (c == strobe_at) && !use_rd;
         data_rd = (c == strobe_at) && use_rd;
         @(negedge clk);
         chk(frame_req, (c == pa) || (c == pb), $sformatf("%s cycle %0d", what, c));
         next_cycle();
      end
      data_wr = 1'b0;
      data_rd = 1'b0;
   endtask

   task automatic idle_one();
      frame_present = 1'b0;
      next_cycle();
   endtask

   initial begin
      #(WATCHDOG);
      if (!finished) begin
         n_fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      // R9: reset holds frame_req low in paced mode with a frame present
      frame_mode_en = 1'b1;
      pace_en       = 1'b1;
      pace_period   = 16'd1;
      frame_present = 1'b1;
      for (int c = 0; c < 70; c++) begin
         @(negedge clk);
         chk(frame_req, 1'b0, $sformatf("R9 in reset cycle %0d", c));
      end
      next_cycle();
      rst_n = 1'b1;
      run_window(66, 63, -1, -1, 1'b0, "R9 first pulse after reset");
      idle_one();

      // Table of static-mode vectors: R1 R2 R3 R8, and R4 no early pulse
      for (int v = 0; v < NVEC; v++) begin
         frame_mode_en = VEC[v][6];
         pace_en       = VEC[v][5];
         pace_period   = VEC[v][4] ? 16'd0 : 16'd1;
         frame_present = VEC[v][3];
         alarm_in      = VEC[v][2];
         @(negedge clk);
         chk(frame_req, VEC[v][1], $sformatf("%s vector %0d frame_req", tag_name(VEC[v][10:7]), v));
         chk(alarm_req, VEC[v][0], $sformatf("R8 vector %0d alarm_req", v));
         next_cycle();
      end
      alarm_in = 1'b0;
      idle_one();

      // R4 R5: period 1, pulses at 63 and 127
      frame_mode_en = 1'b1;
      pace_en       = 1'b1;
      pace_period   = 16'd1;
      next_cycle();
      frame_present = 1'b1;
      run_window(130, 63, 127, -1, 1'b0, "R5 period 1 repeat");
      idle_one();

      // R4: period 3, first pulse at 191
      pace_period = 16'd3;
      next_cycle();
      frame_present = 1'b1;
      run_window(195, 191, -1, -1, 1'b0, "R4 period 3 first pulse");
      idle_one();

      // R6: write in mid-count, period 2, pulse at 50 + 128
      pace_period = 16'd2;
      next_cycle();
      frame_present = 1'b1;
      run_window(181, 178, -1, 50, 1'b0, "R6 write restart");
      idle_one();

      // R6: read in the expiry cycle suppresses it, next at 127
      pace_period = 16'd1;
      next_cycle();
      frame_present = 1'b1;
      run_window(130, 127, -1, 63, 1'b1, "R6 read at expiry");
      idle_one();

      // R7: frame drops in mid-count, count starts over
      frame_present = 1'b1;
      run_window(40, -1, -1, -1, 1'b0, "R7 before drop");
      frame_present = 1'b0;
      run_window(5, -1, -1, -1, 1'b0, "R7 frame absent");
      frame_present = 1'b1;
      run_window(66, 63, -1, -1, 1'b0, "R7 after return");
      idle_one();

      // R1: pacing configured but frame mode off, long window silent
      frame_mode_en = 1'b0;
      frame_present = 1'b1;
      run_window(70, -1, -1, -1, 1'b0, "R1 frame mode off");
      frame_present = 1'b0;

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule